// File: doc/BRIEF.md
# Auto-Incrementing Video Memory Host Port

This block sits between a host processor and a word-organised video memory that only takes whole 16-bit words. The host reaches it through three byte-wide ports, chosen with `host_sel`: a control port, a low data port and a high data port. A byte written to the control port picks which internal register the data ports address. The choices are the write pointer, the read pointer, the step code and the data path.

On the data path, a low byte only loads a holding latch. A high byte combines with the latched low byte into one word. That word is committed at the write pointer, and the pointer then moves forward by the selected step. The latch survives the commit. A run of words that share a low byte therefore needs only one host write per word after the first.

Loading the read pointer starts a prefetch. The fetched word is visible through the low and high data ports. Each high-byte read moves the read pointer forward by the same step and fetches the next word. A display-side busy input delays memory access. Until the pending access completes, a ready flag stays low and host accesses are dropped.

Top module: `vram_port`

## Requirements
- R1: After reset the ready flag is 1, the write pointer, read pointer, latch and step code are 0, and both data ports read back 0.
- R2: Writing byte b to the control port (`host_sel`=0) selects register b[1:0]: 0 write pointer, 1 read pointer, 2 step code, 3 data path. For a pointer, a low-port write sets bits 7:0 and a high-port write sets bits 15:8 of a 16-bit value. That value is taken modulo 2^AW.
- R3: With the data path selected, a low-port write (`host_sel`=1) only loads the latch. It leaves memory contents and the write pointer unchanged.
- R4: With the data path selected, a high-port write (`host_sel`=2) of byte h stores {h, latch} at the write pointer.
- R5: A commit does not clear the latch. Further high-port writes reuse the last low byte.
- R6: After every commit the write pointer advances by the step chosen by the low byte's bits 1:0 written while the step code is selected. The encodings are 00 for +1, 01 for +32, 10 for +64 and 11 for +128. The pointer wraps modulo 2^AW.
- R7: A commit lowers ready in the next cycle. With `disp_busy` low the word is written on the following edge and ready returns one cycle after the commit. While `disp_busy` is high the word is held and ready stays low.
- R8: Host writes and reads issued while ready is low are ignored.
- R9: Loading either byte of the read pointer starts a prefetch. When memory is free, ready is low for two cycles and then the low and high data ports return bits 7:0 and 15:8 of the word at the read pointer. A busy display delays the prefetch.
- R10: A host read of the high data port advances the read pointer by the current step and prefetches the next word with the same two-cycle timing.
- R11: Reading the control port returns 8'h01 when ready and 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_sel | input | 2 | Port select: 0 control, 1 low data, 2 high data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected port |
| host_ready | output | 1 | No memory access outstanding |
| disp_busy | input | 1 | Display fetch owns the memory |

## Verification
Every memory access costs a known number of edges when the display is idle. A commit keeps ready low for one cycle. A prefetch keeps it low for two cycles, after which the data ports hold the new word. The bench samples ready at exactly those negative edges after each accepted write or read, so any extra or missing pipeline stage is reported. While busy is held, it checks ready on each cycle and then counts the edges from busy release to ready. It reads data back only after ready has risen, comparing it with a word image that the bench maintains from the step arithmetic.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  // Internal register chosen through the control port
  typedef enum logic [1:0] {
    TGT_WPTR = 2'd0,
    TGT_RPTR = 2'd1,
    TGT_STEP = 2'd2,
    TGT_DATA = 2'd3
  } target_e;

  // Host port codes
  localparam logic [1:0] PORT_CTRL = 2'd0;
  localparam logic [1:0] PORT_LO   = 2'd1;
  localparam logic [1:0] PORT_HI   = 2'd2;

  // Pointer step for a 2-bit code: 1, 32, 64, 128 words
  function automatic logic [7:0] step_words(input logic [1:0] code);
    logic [7:0] s;
    case (code)
      2'd0:    s = 8'd1;
      2'd1:    s = 8'd32;
      2'd2:    s = 8'd64;
      default: s = 8'd128;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vram_port_regs.sv
module vram_port_regs
  import vram_port_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [1:0]    host_sel,
  input  logic [7:0]    host_wdata,
  input  logic          ready,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [15:0]   commit_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr
);

  target_e       target_q, target_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [7:0]    lat_q, lat_d;
  logic [1:0]    code_q, code_d;
  logic [AW-1:0] step;
  logic [15:0]   wptr16, rptr16;
  logic          wr_ok, rd_ok, upd_en;

  assign step   = AW'(step_words(code_q));
  assign wptr16 = 16'(wptr_q);
  assign rptr16 = 16'(rptr_q);
  assign wr_ok  = host_we && ready;
  assign rd_ok  = host_re && ready;
  assign upd_en = wr_ok || rd_ok;

  always_comb begin
    target_d = target_q;
    wptr_d   = wptr_q;
    rptr_d   = rptr_q;
    lat_d    = lat_q;
    code_d   = code_q;
    commit   = 1'b0;
    rd_req   = 1'b0;
    if (wr_ok) begin
      if (host_sel == PORT_CTRL) begin
        target_d = target_e'(host_wdata[1:0]);
      end else if (host_sel == PORT_LO) begin
        case (target_q)
          TGT_WPTR: wptr_d = AW'({wptr16[15:8], host_wdata});
          TGT_RPTR: begin
            rptr_d = AW'({rptr16[15:8], host_wdata});
            rd_req = 1'b1;
          end
          TGT_STEP: code_d = host_wdata[1:0];
          default:  lat_d  = host_wdata;
        endcase
      end else if (host_sel == PORT_HI) begin
        case (target_q)
          TGT_WPTR: wptr_d = AW'({host_wdata, wptr16[7:0]});
          TGT_RPTR: begin
            rptr_d = AW'({host_wdata, rptr16[7:0]});
            rd_req = 1'b1;
          end
          TGT_STEP: ;
          default: begin
            commit = 1'b1;
            wptr_d = wptr_q + step;
          end
        endcase
      end
    end else if (rd_ok && host_sel == PORT_HI) begin
      rptr_d = rptr_q + step;
      rd_req = 1'b1;
    end
  end

  assign commit_addr = wptr_q;
  assign commit_data = {host_wdata, lat_q};
  assign rd_addr     = rptr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= TGT_WPTR;
      wptr_q   <= '0;
      rptr_q   <= '0;
      lat_q    <= '0;
      code_q   <= '0;
    end else if (upd_en) begin
      target_q <= target_d;
      wptr_q   <= wptr_d;
      rptr_q   <= rptr_d;
      lat_q    <= lat_d;
      code_q   <= code_d;
    end
  end

  // R5: the holding latch survives a commit
  assert_latch_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> $stable(lat_q));

  // R6: consecutive commit addresses differ by the step in force
  assert_step_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (commit_addr == AW'($past(commit_addr) + AW'(step_words($past(code_q))))));

  // R8: nothing the host does while not ready reaches the registers
  assert_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(wptr_q) && $stable(rptr_q) && $stable(lat_q) && $stable(code_q)));

endmodule

// File: rtl/vram_port_sched.sv
module vram_port_sched #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] commit_addr,
  input  logic [15:0]   commit_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          disp_busy,
  input  logic [15:0]   mem_q,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [15:0]   mem_wdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [15:0]   rd_word,
  output logic          ready
);

  logic          wr_pend_q, wr_pend_d;
  logic [AW-1:0] wbuf_addr_q, wbuf_addr_d;
  logic [15:0]   wbuf_data_q, wbuf_data_d;
  logic          rd_pend_q, rd_pend_d;
  logic [AW-1:0] rbuf_addr_q, rbuf_addr_d;
  logic          rd_cap_q, rd_cap_d;
  logic [15:0]   rd_word_q, rd_word_d;

  // Pending write goes first so a read sees the latest data
  assign mem_we    = wr_pend_q && !disp_busy;
  assign mem_re    = rd_pend_q && !wr_pend_q && !disp_busy;
  assign mem_waddr = wbuf_addr_q;
  assign mem_wdata = wbuf_data_q;
  assign mem_raddr = rbuf_addr_q;
  assign ready     = !(wr_pend_q || rd_pend_q || rd_cap_q);
  assign rd_word   = rd_word_q;

  always_comb begin
    wr_pend_d   = wr_pend_q;
    wbuf_addr_d = wbuf_addr_q;
    wbuf_data_d = wbuf_data_q;
    rd_pend_d   = rd_pend_q;
    rbuf_addr_d = rbuf_addr_q;
    rd_cap_d    = mem_re;
    rd_word_d   = rd_word_q;
    if (commit) begin
      wr_pend_d   = 1'b1;
      wbuf_addr_d = commit_addr;
      wbuf_data_d = commit_data;
    end else if (mem_we) begin
      wr_pend_d = 1'b0;
    end
    if (rd_req) begin
      rd_pend_d   = 1'b1;
      rbuf_addr_d = rd_addr;
    end else if (mem_re) begin
      rd_pend_d = 1'b0;
    end
    if (rd_cap_q) rd_word_d = mem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend_q   <= 1'b0;
      wbuf_addr_q <= '0;
      wbuf_data_q <= '0;
      rd_pend_q   <= 1'b0;
      rbuf_addr_q <= '0;
      rd_cap_q    <= 1'b0;
      rd_word_q   <= '0;
    end else begin
      wr_pend_q <= wr_pend_d;
      rd_pend_q <= rd_pend_d;
      rd_cap_q  <= rd_cap_d;
      if (commit) begin
        wbuf_addr_q <= wbuf_addr_d;
        wbuf_data_q <= wbuf_data_d;
      end
      if (rd_req) rbuf_addr_q <= rbuf_addr_d;
      if (rd_cap_q) rd_word_q <= rd_word_d;
    end
  end

  // R7: a held write stays held while the display is busy
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend_q && disp_busy) |=> wr_pend_q);

  // R7: a commit is reflected as not-ready on the next cycle
  assert_commit_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !ready);

  // R9: a memory read finishes two cycles later with ready high
  assert_read_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !ready ##1 ready);

endmodule

// File: rtl/vram_port_mem.sv
module vram_port_mem #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   q
);

  localparam int DEPTH = 1 << AW;

  logic [15:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
    if (re) q <= words[raddr];
  end

endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_re,
  input  logic [1:0] host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_ready,
  input  logic       disp_busy
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          commit, rd_req, ready;
  logic [AW-1:0] commit_addr, rd_addr;
  logic [15:0]   commit_data;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [15:0]   mem_wdata, mem_q, rd_word;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  vram_port_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_int_n),
    .host_we(host_we), .host_re(host_re), .host_sel(host_sel),
    .host_wdata(host_wdata), .ready(ready),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
    .rd_req(rd_req), .rd_addr(rd_addr)
  );

  vram_port_sched #(.AW(AW)) sched_i (
    .clk(clk), .rst_n(rst_int_n),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .disp_busy(disp_busy),
    .mem_q(mem_q), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .rd_word(rd_word), .ready(ready)
  );

  vram_port_mem #(.AW(AW)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .q(mem_q)
  );

  always_comb begin
    case (host_sel)
      PORT_CTRL: host_rdata = {7'd0, ready};
      PORT_LO:   host_rdata = rd_word[7:0];
      PORT_HI:   host_rdata = rd_word[15:8];
      default:   host_rdata = 8'd0;
    endcase
  end

  assign host_ready = ready;

endmodule

// File: tb/vram_port_tb_top.sv
`timescale 1ns/1ps
module vram_port_tb_top;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_we, host_re, disp_busy;
  logic [1:0] host_sel;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       host_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  vram_port #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .disp_busy(disp_busy)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic re, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_we = we; host_re = re; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_re = 1'b0;
  endtask

  task automatic wait_ready();
    while (!host_ready) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    drive(1'b1, 1'b0, sel, d);
    wait_ready();
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] v);
    host_sel = sel;
    #1;
    v = host_rdata;
  endtask

  function automatic int step_of(input int code);
    return (code == 0) ? 1 : (code == 1) ? 32 : (code == 2) ? 64 : 128;
  endfunction

  // Load the read pointer; the last byte is timed for R9
  task automatic set_rptr(input int a);
    wr(2'd0, 8'd1);
    wr(2'd1, 8'(a));
    drive(1'b1, 1'b0, 2'd2, 8'(a >> 8));
    chk({31'd0, host_ready}, 32'd0, "R9 prefetch cycle 1 not ready");
    @(negedge clk);
    chk({31'd0, host_ready}, 32'd0, "R9 prefetch cycle 2 not ready");
    @(negedge clk);
    chk({31'd0, host_ready}, 32'd1, "R9 prefetch ready after 2");
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    peek(2'd1, lo);
    peek(2'd2, hi);
    w = {hi, lo};
  endtask

  // R10: read high byte, advance and prefetch
  task automatic read_next();
    drive(1'b0, 1'b1, 2'd2, 8'd0);
    chk({31'd0, host_ready}, 32'd0, "R10 advance not ready");
    @(negedge clk);
    @(negedge clk);
    chk({31'd0, host_ready}, 32'd1, "R10 ready after 2");
  endtask

  task automatic set_wptr(input int a);
    wr(2'd0, 8'd0);
    wr(2'd1, 8'(a));
    wr(2'd2, 8'(a >> 8));
  endtask

  // Timed commit; caller has the data path selected
  task automatic commit(input logic [7:0] hi);
    drive(1'b1, 1'b0, 2'd2, hi);
    chk({31'd0, host_ready}, 32'd0, "R7 commit not ready");
    @(negedge clk);
    chk({31'd0, host_ready}, 32'd1, "R7 commit ready after 1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] w;
    int addr, step, base;
    logic [7:0] lat;
    host_we = 0; host_re = 0; host_sel = 0; host_wdata = 0; disp_busy = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R11 reset state
    chk({31'd0, host_ready}, 32'd1, "R1 ready after reset");
    peek(2'd0, v); chk(v, 8'h01, "R11 status ready");
    peek(2'd1, v); chk(v, 8'h00, "R1 low data reset");
    peek(2'd2, v); chk(v, 8'h00, "R1 high data reset");

    // R4 R5 R6: every step code, crossing the top of memory
    for (int code = 0; code < 4; code++) begin
      step = step_of(code);
      base = 1000 + code * 5;
      wr(2'd0, 8'd2);
      wr(2'd1, 8'(code));
      set_wptr(base);
      wr(2'd0, 8'd3);
      lat = 8'h10 + 8'(code);
      wr(2'd1, lat);
      addr = base;
      for (int k = 0; k < 6; k++) begin
        logic [7:0] hi;
        if (k == 3) begin
          lat = 8'h70 + 8'(code);
          wr(2'd1, lat);
        end
        hi = 8'hA0 + 8'(k * 3 + code);
        commit(hi);
        model[addr] = {hi, lat};
        addr = (addr + step) % DEPTH;
      end
      set_rptr(base);
      addr = base;
      for (int k = 0; k < 6; k++) begin
        read_word(w);
        chk(w, model[addr], $sformatf("R4 R5 R6 code %0d word %0d", code, k));
        read_next();
        addr = (addr + step) % DEPTH;
      end
    end

    // R3: low byte alone leaves memory and pointer untouched; R5 reuse
    wr(2'd0, 8'd2); wr(2'd1, 8'd0);
    set_wptr(200);
    wr(2'd0, 8'd3);
    wr(2'd1, 8'h11);
    commit(8'h22);
    set_wptr(200);
    wr(2'd0, 8'd3);
    wr(2'd1, 8'h5A);
    set_rptr(200);
    read_word(w);
    chk(w, 16'h2211, "R3 low write no memory change");
    wr(2'd0, 8'd3);
    commit(8'h77);
    commit(8'h78);
    set_rptr(200);
    read_word(w); chk(w, 16'h775A, "R3 pointer unchanged by low write");
    read_next();
    read_word(w); chk(w, 16'h785A, "R5 latch reused");

    // R7 R8: busy holds the commit, host accesses dropped
    set_wptr(300);
    wr(2'd0, 8'd3);
    wr(2'd1, 8'h33);
    disp_busy = 1'b1;
    drive(1'b1, 1'b0, 2'd2, 8'h44);
    for (int i = 0; i < 4; i++) begin
      chk({31'd0, host_ready}, 32'd0, "R7 held while busy");
      @(negedge clk);
    end
    drive(1'b1, 1'b0, 2'd1, 8'h99);
    drive(1'b1, 1'b0, 2'd2, 8'h55);
    drive(1'b1, 1'b0, 2'd0, 8'h00);
    drive(1'b0, 1'b1, 2'd2, 8'h00);
    peek(2'd0, v); chk(v, 8'h00, "R11 status not ready");
    disp_busy = 1'b0;
    @(negedge clk);
    chk({31'd0, host_ready}, 32'd1, "R7 written on first free cycle");
    commit(8'h66);
    set_rptr(300);
    read_word(w); chk(w, 16'h4433, "R7 held word landed");
    read_next();
    read_word(w); chk(w, 16'h6633, "R8 ignored writes had no effect");

    // R9: prefetch delayed by busy
    wr(2'd0, 8'd1);
    wr(2'd1, 8'(300));
    disp_busy = 1'b1;
    drive(1'b1, 1'b0, 2'd2, 8'(300 >> 8));
    repeat (3) begin
      chk({31'd0, host_ready}, 32'd0, "R9 prefetch held by busy");
      @(negedge clk);
    end
    disp_busy = 1'b0;
    @(negedge clk);
    chk({31'd0, host_ready}, 32'd0, "R9 capture cycle");
    @(negedge clk);
    chk({31'd0, host_ready}, 32'd1, "R9 ready after busy");
    read_word(w); chk(w, 16'h4433, "R9 data after busy");

    // R2: pointer high bits truncated modulo memory size
    set_wptr(16'hFF05);
    wr(2'd0, 8'd3);
    wr(2'd1, 8'hC3);
    commit(8'hB2);
    set_rptr(16'h0305);
    read_word(w); chk(w, 16'hB2C3, "R2 pointer modulo memory size");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule